// File: doc/BRIEF.md
# ASID-Tagged Address Translation Buffer

This block converts a 32-bit virtual address into a 29-bit physical address. It uses a small fully associative buffer of translation entries. Each entry stores a virtual page number, an 8-bit address space identifier (ASID), a physical page number, a shared flag and a valid flag. Pages are 4 KB, so the low 12 address bits pass through unchanged. Software loads entries through a write port. The slot that each write fills is picked by a round-robin pointer. A synchronous invalidate-all input empties the buffer.

Two control bits and an ASID register set how lookups behave. When translation is off, the physical address is the virtual address with its top three bits dropped, so all segments alias onto one physical space. When translation is on, the mode bit chooses between two compare rules:

- In multiple-space mode an entry must match on both page number and ASID. Switching the ASID therefore needs no flush.
- In single-space mode a page match with the wrong ASID is reported as a protection violation rather than as a hit.

Entries marked shared ignore the ASID in both modes. Each lookup is answered one cycle later with exactly one of three results: hit, miss or protection violation. If more than one entry hits, an error flag is raised next to the hit. A missed access can simply be presented again once software has loaded the entry.

Top module: `asid_tlb_xlate`

## Requirements
- R1: After reset, translation is off, single-space mode is selected, the current ASID is 0, no entry is valid, the replacement pointer is at slot 0 and `rsp_valid` is low.
- R2: A lookup presented with `req_valid` is answered with `rsp_valid` high on the next cycle. The answer reflects the entries, control bits and ASID as they stood before that clock edge, so a write, an invalidate or a register update in the same cycle is not visible to it.
- R3: With translation off, `rsp_pa` equals bits 28:0 of the virtual address and `rsp_hit` is set. For example, 0x00001000, 0x80001000, 0xA0001000 and 0xC0001000 all give 0x00001000.
- R4: On a hit, `rsp_pa` is the entry's 17-bit physical page number in bits 28:12, followed by virtual address bits 11:0.
- R5: In multiple-space mode, a non-shared entry hits only when it is valid, its page number equals virtual address bits 31:12, and its ASID equals the current ASID. Otherwise the result is a miss.
- R6: A valid shared entry whose page number matches hits whatever its ASID is, in both modes.
- R7: In single-space mode, if no entry hits but a valid non-shared entry matches on page number with a different ASID, the result is `rsp_prot` with `rsp_pa` = 0. Multiple-space mode never reports `rsp_prot`.
- R8: When nothing matches, `rsp_miss` is set and `rsp_pa` = 0. Every response sets exactly one of `rsp_hit`, `rsp_miss` and `rsp_prot`, and all flags are low when `rsp_valid` is low.
- R9: When two or more entries hit, `rsp_multi` is set together with `rsp_hit`, and the physical page comes from the lowest-indexed hitting entry.
- R10: Writes fill slots 0, 1, … 15 in order and then wrap to slot 0, overwriting it. Invalidate-all returns the pointer to slot 0.
- R11: `inval_all` clears every valid bit at the clock edge. A write presented in the same cycle is dropped.
- R12: `ctl_we` loads `ctl_xlat_en` and `ctl_multi`, and `asid_we` loads the 8-bit current ASID. Both take effect for lookups presented from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Load control bits |
| ctl_xlat_en | input | 1 | Translation enable value (1 = translate) |
| ctl_multi | input | 1 | Mode value (1 = multiple-space, 0 = single-space) |
| asid_we | input | 1 | Load current ASID |
| asid_wdata | input | 8 | New current ASID |
| inval_all | input | 1 | Invalidate every entry |
| wr_en | input | 1 | Write an entry at the round-robin slot |
| wr_vpn | input | 20 | Entry virtual page number |
| wr_asid | input | 8 | Entry ASID |
| wr_ppn | input | 17 | Entry physical page number |
| wr_shared | input | 1 | Entry ignores ASID |
| wr_valid | input | 1 | Entry valid bit |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_pa | output | 29 | Physical address |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No matching entry |
| rsp_prot | output | 1 | ASID protection violation (single-space mode) |
| rsp_multi | output | 1 | More than one entry hit |

## Verification
A lookup can land in the same cycle as an entry write or an invalidate-all. An invalidate-all can also land in the same cycle as an entry write. The bench provokes each pairing by driving both inputs on the same clock edge:

- A lookup to a page that is being written in that same cycle must still miss. Repeating it one cycle later must hit.
- A lookup issued alongside an invalidate must still hit on the old contents, and a later lookup must miss.
- A write issued alongside an invalidate must leave no trace. A following lookup of that page misses, and a later write lands in slot 0.

// File: rtl/asid_tlb_xlate.sv
module asid_tlb_xlate #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 29,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic                   ctl_xlat_en,
  input  logic                   ctl_multi,
  input  logic                   asid_we,
  input  logic [ASID_W-1:0]      asid_wdata,
  input  logic                   inval_all,
  input  logic                   wr_en,
  input  logic [VA_W-PAGE_W-1:0] wr_vpn,
  input  logic [ASID_W-1:0]      wr_asid,
  input  logic [PA_W-PAGE_W-1:0] wr_ppn,
  input  logic                   wr_shared,
  input  logic                   wr_valid,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_va,
  output logic                   rsp_valid,
  output logic [PA_W-1:0]        rsp_pa,
  output logic                   rsp_hit,
  output logic                   rsp_miss,
  output logic                   rsp_prot,
  output logic                   rsp_multi
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PPN_W = PA_W - PAGE_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic              xlat_en_q, multi_q;
  logic [ASID_W-1:0] asid_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [ENTRIES-1:0] valid_q, shared_q;
  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [ASID_W-1:0] tag_q  [ENTRIES];
  logic [PPN_W-1:0]  ppn_q  [ENTRIES];

  logic [ENTRIES-1:0] vpn_m, asid_ok, hit_vec, prot_vec;
  logic [PPN_W-1:0]   sel_ppn;
  logic               many;
  logic               do_wr;

  assign do_wr = wr_en && !inval_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat_en_q <= 1'b0;
      multi_q   <= 1'b0;
      asid_q    <= '0;
    end else begin
      if (ctl_we) begin
        xlat_en_q <= ctl_xlat_en;
        multi_q   <= ctl_multi;
      end
      if (asid_we) asid_q <= asid_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (inval_all) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (wr_en) begin
      valid_q[ptr_q] <= wr_valid;
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      vpn_q[ptr_q]    <= wr_vpn;
      tag_q[ptr_q]    <= wr_asid;
      ppn_q[ptr_q]    <= wr_ppn;
      shared_q[ptr_q] <= wr_shared;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign vpn_m[i]   = valid_q[i] && (vpn_q[i] == req_va[VA_W-1:PAGE_W]);
    assign asid_ok[i] = shared_q[i] || (tag_q[i] == asid_q);
  end

  assign hit_vec  = vpn_m & asid_ok;
  assign prot_vec = vpn_m & ~asid_ok;
  assign many     = |(hit_vec & (hit_vec - 1'b1));

  always_comb begin
    sel_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel_ppn = ppn_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_multi <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_pa    <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_multi <= 1'b0;
      if (req_valid) begin
        if (!xlat_en_q) begin
          rsp_pa  <= req_va[PA_W-1:0];
          rsp_hit <= 1'b1;
        end else if (|hit_vec) begin
          rsp_pa    <= {sel_ppn, req_va[PAGE_W-1:0]};
          rsp_hit   <= 1'b1;
          rsp_multi <= many;
        end else if (!multi_q && |prot_vec) begin
          rsp_prot <= 1'b1;
        end else begin
          rsp_miss <= 1'b1;
        end
      end
    end
  end

  a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_prot}));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot || rsp_multi));
  a_r3_bypass_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(xlat_en_q)) |-> (rsp_hit && rsp_pa == $past(req_va[PA_W-1:0])));
  a_r7_no_prot_multi: assert property (@(posedge clk) disable iff (!rst_n)
    $past(multi_q) |-> !rsp_prot);
  a_r9_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);
  a_r11_inval_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> (valid_q == '0 && ptr_q == '0));
  a_r10_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
endmodule

// File: tb/asid_tlb_xlate_bench.sv
module asid_tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 0, ctl_xlat_en = 0, ctl_multi = 0;
  logic        asid_we = 0;
  logic [7:0]  asid_wdata = '0;
  logic        inval_all = 0, wr_en = 0, wr_shared = 0, wr_valid = 0;
  logic [19:0] wr_vpn = '0;
  logic [7:0]  wr_asid = '0;
  logic [16:0] wr_ppn = '0;
  logic        req_valid = 0;
  logic [31:0] req_va = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_multi;
  logic [28:0] rsp_pa;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  asid_tlb_xlate u_asid_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_xlat_en(ctl_xlat_en),
    .ctl_multi(ctl_multi), .asid_we(asid_we), .asid_wdata(asid_wdata),
    .inval_all(inval_all), .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_ppn(wr_ppn), .wr_shared(wr_shared), .wr_valid(wr_valid),
    .req_valid(req_valid), .req_va(req_va), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_prot(rsp_prot), .rsp_multi(rsp_multi));

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [33:0] res(input logic h, m, p, x, input logic [28:0] pa);
    return {1'b1, h, m, p, x, pa};
  endfunction

  task automatic set_ctl(input logic en, input logic mm);
    @(negedge clk); ctl_we = 1; ctl_xlat_en = en; ctl_multi = mm;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk); asid_we = 1; asid_wdata = a;
    @(negedge clk); asid_we = 0;
  endtask

  task automatic put(input logic [19:0] v, input logic [7:0] a, input logic [16:0] p, input logic s);
    @(negedge clk); wr_en = 1; wr_vpn = v; wr_asid = a; wr_ppn = p; wr_shared = s; wr_valid = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic [33:0] exp);
    @(negedge clk); req_valid = 1; req_va = va;
    @(posedge clk); #1;
    check(tag, {rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_multi, rsp_pa}, exp);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    check("R1 reset outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_multi, rsp_pa}, '0);
    look("R1 default bypass", 32'h0040_0ABC, res(1,0,0,0,29'h0040_0ABC));
  endtask

  task automatic t_bypass;
    look("R3 alias P0", 32'h0000_1000, res(1,0,0,0,29'h1000));
    look("R3 alias P1", 32'h8000_1000, res(1,0,0,0,29'h1000));
    look("R3 alias P2", 32'hA000_1000, res(1,0,0,0,29'h1000));
    look("R3 alias P3", 32'hC000_1000, res(1,0,0,0,29'h1000));
  endtask

  task automatic t_multi_mode;
    put(20'h00400, 8'd5, 17'h00123, 0);
    put(20'h00500, 8'd9, 17'h00200, 1);
    set_ctl(1, 1);
    set_asid(8'd5);
    look("R4 R5 R12 hit", 32'h0040_0ABC, res(1,0,0,0,29'h123ABC));
    set_asid(8'd6);
    look("R5 asid mismatch miss", 32'h0040_0ABC, res(0,1,0,0,29'h0));
    look("R6 shared hit multi", 32'h0050_0010, res(1,0,0,0,29'h200010));
  endtask

  task automatic t_single_mode;
    set_ctl(1, 0);
    look("R7 protection", 32'h0040_0ABC, res(0,0,1,0,29'h0));
    look("R6 shared hit single", 32'h0050_0010, res(1,0,0,0,29'h200010));
    set_asid(8'd5);
    look("R7 own asid hit", 32'h0040_0ABC, res(1,0,0,0,29'h123ABC));
    set_ctl(1, 1);
  endtask

  task automatic t_miss_retry;
    look("R8 miss", 32'h0060_0000, res(0,1,0,0,29'h0));
    put(20'h00600, 8'd5, 17'h00042, 0);
    look("R8 retry hit", 32'h0060_0000, res(1,0,0,0,29'h42000));
  endtask

  task automatic t_multi_hit;
    put(20'h00400, 8'd5, 17'h00777, 0);
    look("R9 lowest index", 32'h0040_0ABC, res(1,0,0,1,29'h123ABC));
  endtask

  task automatic t_write_vs_lookup;
    @(negedge clk); wr_en = 1; wr_vpn = 20'h00700; wr_asid = 8'd5; wr_ppn = 17'h55;
    wr_shared = 0; wr_valid = 1; req_valid = 1; req_va = 32'h0070_0123;
    @(posedge clk); #1;
    check("R2 lookup sees old table", {rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_multi, rsp_pa}, res(0,1,0,0,29'h0));
    @(negedge clk); wr_en = 0; req_valid = 0;
    look("R2 then hit", 32'h0070_0123, res(1,0,0,0,29'h55123));
  endtask

  task automatic t_inval;
    @(negedge clk); inval_all = 1; req_valid = 1; req_va = 32'h0040_0ABC;
    @(posedge clk); #1;
    check("R2 R11 lookup before inval", {rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_multi, rsp_pa}, res(1,0,0,1,29'h123ABC));
    @(negedge clk); inval_all = 0; req_valid = 0;
    look("R11 gone after inval", 32'h0040_0ABC, res(0,1,0,0,29'h0));
    @(negedge clk); inval_all = 1; wr_en = 1; wr_vpn = 20'h00800; wr_asid = 8'd5;
    wr_ppn = 17'h99; wr_shared = 0; wr_valid = 1;
    @(negedge clk); inval_all = 0; wr_en = 0;
    look("R11 write dropped", 32'h0080_0000, res(0,1,0,0,29'h0));
  endtask

  task automatic t_round_robin;
    for (int i = 0; i < 16; i++) put(20'h00100 + 20'(i), 8'd5, 17'h00300 + 17'(i), 0);
    put(20'h00900, 8'd5, 17'h001AB, 0);
    look("R10 slot0 overwritten", 32'h0010_0000, res(0,1,0,0,29'h0));
    look("R10 slot1 kept", 32'h0010_1004, res(1,0,0,0,29'h301004));
    look("R10 wrapped entry", 32'h0090_0008, res(1,0,0,0,29'h1AB008));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_bypass();
    t_multi_mode();
    t_single_mode();
    t_miss_retry();
    t_multi_hit();
    t_write_vs_lookup();
    t_inval();
    t_round_robin();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule